// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block sits between on-chip logic and an external asynchronous static RAM with a 16-bit word, an 18-bit word address and two byte lanes. The on-chip side issues single-word reads or writes using a level request that is held, with its fields stable, until a one-cycle acknowledge returns. The controller turns each request into registered memory strobes. All timing is counted in clock cycles, and those counts are derived at elaboration from the memory's nanosecond limits. The inputs to that derivation are the clock period and the speed grade, either 55 ns or 70 ns.

When no access is in progress, the memory is held in standby. Both chip selects are inactive, both byte strobes are high and the data bus is released. A read asserts the chip selects, output enable and the byte strobes of the requested lanes for one full read cycle, then registers the data on the last cycle of the access. A write first waits for the memory's output to float. It then drives the bus one cycle before write enable falls, holds write enable low long enough to meet both the pulse and the data-setup limits, and keeps driving for one cycle after write enable rises. After every write, the bus stays released for at least one cycle before a read can turn output enable on.

Top module: `srbus_ctrl`

## Requirements
- R1: After reset, and in every cycle without an access, the controller holds the memory in standby: `mem_cs_n`=1, `mem_cs_hi`=0, both `mem_lane_n` bits 1, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: A read holds `mem_cs_n`=0, `mem_cs_hi`=1, `mem_we_n`=1 and `mem_oe_n`=0 at a stable address. It registers the word into `rsp_rdata` from `mem_dq_in` sampled on the last cycle of the access.
- R3: In `req_be`, bit 0 selects the lower lane (data bits 7:0, strobe `mem_lane_n[0]`) and bit 1 selects the upper lane (bits 15:8, strobe `mem_lane_n[1]`). A read strobes only the enabled lanes, and a disabled lane reads back as zero.
- R4: A write keeps `mem_oe_n` high throughout. It drives the bus in the cycle before `mem_we_n` falls, in every cycle that `mem_we_n` is low and in the cycle after it rises. The low pulse lasts at least ceil(max(pulse, setup) / clock period) cycles, with the data stable over that span.
- R5: A write updates only the lanes enabled in `req_be`. A write with `req_be`=0 leaves the memory contents unchanged.
- R6: `req_ack` is high for exactly one cycle per accepted request. A request is accepted only in an idle cycle in which `req_ack` is low.
- R7: After a write, the bus is released for at least one cycle before `mem_oe_n` falls for a following read.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low. The bus is driven only after `mem_oe_n` has been high for more than ceil(20 ns / clock period) cycles.
- R9: The read strobe lasts at least ceil(max(read cycle, output-enable access) / clock period) cycles. These limits are 55/35 ns for grade 55 and 70/40 ns for grade 70, and each count is at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | LANES*LANE_W | Write word |
| req_be | input | LANES | Lane enables, bit 0 = lower lane |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LANES*LANE_W | Read word, disabled lanes zero |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs_hi | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lane_n | output | LANES | Active-low byte strobes, bit 0 = lower lane |
| mem_dq_out | output | LANES*LANE_W | Data driven to memory |
| mem_dq_in | input | LANES*LANE_W | Data returned by memory |
| mem_dq_oe | output | 1 | Bus drive enable |

## Verification
Two events can land in the same cycle: the completion acknowledge and the presentation of the next request. A requester that holds `req_valid` high must have the new request taken once, never twice, and a write followed at once by a read must still open a released-bus gap before output enable falls. The bench provokes both by changing the request fields in the very cycle the acknowledge is seen and leaving `req_valid` high. Write-to-read, read-to-read and write-to-write chains are all run, including an access at the top address. The scoreboard pairs each acknowledge with exactly one queued expectation. A memory model returns garbage until the read has aged enough and measures the released cycles before each output-enable fall.

// File: rtl/srbus_pkg.sv
package srbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WGAP,
    ST_WDRV,
    ST_WPULSE,
    ST_WHOLD,
    ST_TURN
  } srb_state_t;

  typedef enum int {
    LIM_RC,
    LIM_OE,
    LIM_WC,
    LIM_PWE,
    LIM_SD,
    LIM_WHZ
  } srb_limit_t;

  // Nanosecond limit for a grade; any grade slower than 55 uses the 70 set.
  function automatic int limit_ns(int grade_ns, srb_limit_t lim);
    bit slow;
    slow = (grade_ns > 55);
    case (lim)
      LIM_RC:  return slow ? 70 : 55;
      LIM_WC:  return slow ? 70 : 55;
      LIM_OE:  return slow ? 40 : 35;
      LIM_PWE: return slow ? 50 : 40;
      LIM_SD:  return slow ? 30 : 25;
      default: return 20;
    endcase
  endfunction

  function automatic int ns_to_cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rd_cycles(int grade_ns, int clk_ns);
    return imax(ns_to_cyc(limit_ns(grade_ns, LIM_RC), clk_ns),
                ns_to_cyc(limit_ns(grade_ns, LIM_OE), clk_ns));
  endfunction

  function automatic int gap_cycles(int grade_ns, int clk_ns);
    return ns_to_cyc(limit_ns(grade_ns, LIM_WHZ), clk_ns);
  endfunction

  function automatic int pulse_min(int grade_ns, int clk_ns);
    return imax(ns_to_cyc(limit_ns(grade_ns, LIM_PWE), clk_ns),
                ns_to_cyc(limit_ns(grade_ns, LIM_SD), clk_ns));
  endfunction

  // Pulse also stretched so the whole write spans the write-cycle limit.
  function automatic int pulse_cycles(int grade_ns, int clk_ns);
    return imax(pulse_min(grade_ns, clk_ns),
                ns_to_cyc(limit_ns(grade_ns, LIM_WC), clk_ns)
                - gap_cycles(grade_ns, clk_ns) - 2);
  endfunction

endpackage

// File: rtl/srbus_timer.sv
module srbus_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/srbus_lane.sv
module srbus_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept,
  input  logic         en_in,
  input  logic [W-1:0] wdata_in,
  input  logic         sel_nxt,
  input  logic         capture,
  input  logic [W-1:0] dq_in,
  output logic         strobe_n,
  output logic [W-1:0] dq_out,
  output logic [W-1:0] rdata
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      strobe_n <= 1'b1;
      dq_out   <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        en_q   <= en_in;
        dq_out <= wdata_in;
      end
      strobe_n <= !(sel_nxt && (accept ? en_in : en_q));
      if (capture) begin
        rdata <= en_q ? dq_in : '0;
      end
    end
  end

endmodule

// File: rtl/srbus_seq.sv
module srbus_seq
  import srbus_pkg::*;
#(
  parameter int CLK_NS   = 4,
  parameter int GRADE_NS = 55
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic accept,
  output logic capture,
  output logic sel_nxt,
  output logic cs_n,
  output logic cs_hi,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe,
  output logic ack
);

  localparam int RD_CYC    = rd_cycles(GRADE_NS, CLK_NS);
  localparam int GAP_CYC   = gap_cycles(GRADE_NS, CLK_NS);
  localparam int PULSE_CYC = pulse_cycles(GRADE_NS, CLK_NS);
  localparam int CNT_MAX   = imax(imax(RD_CYC, GAP_CYC), PULSE_CYC);
  localparam int CW        = $clog2(CNT_MAX + 1);

  srb_state_t    state, nxt;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          expired;

  srbus_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid && !ack) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            nxt     = ST_WGAP;
            tmr_val = CW'(GAP_CYC - 1);
          end else begin
            nxt     = ST_RD;
            tmr_val = CW'(RD_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (expired) begin
          nxt     = ST_IDLE;
          capture = 1'b1;
        end
      end
      ST_WGAP: begin
        if (expired) nxt = ST_WDRV;
      end
      ST_WDRV: begin
        nxt      = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CW'(PULSE_CYC - 1);
      end
      ST_WPULSE: begin
        if (expired) nxt = ST_WHOLD;
      end
      ST_WHOLD: nxt = ST_TURN;
      ST_TURN:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign sel_nxt = (nxt == ST_RD) || (nxt == ST_WGAP) || (nxt == ST_WDRV) ||
                   (nxt == ST_WPULSE) || (nxt == ST_WHOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cs_n  <= 1'b1;
      cs_hi <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      ack   <= 1'b0;
    end else begin
      state <= nxt;
      cs_n  <= !sel_nxt;
      cs_hi <= sel_nxt;
      oe_n  <= (nxt != ST_RD);
      we_n  <= (nxt != ST_WPULSE);
      dq_oe <= (nxt == ST_WDRV) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
      ack   <= capture || (state == ST_WHOLD);
    end
  end

endmodule

// File: rtl/srbus_ctrl.sv
module srbus_ctrl #(
  parameter int CLK_NS   = 4,
  parameter int GRADE_NS = 55,
  parameter int AW       = 18,
  parameter int LANE_W   = 8,
  parameter int LANES    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_be,
  output logic                    req_ack,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_cs_n,
  output logic                    mem_cs_hi,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic [LANES-1:0]        mem_lane_n,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  input  logic [LANES*LANE_W-1:0] mem_dq_in,
  output logic                    mem_dq_oe
);

  logic accept;
  logic capture;
  logic sel_nxt;

  srbus_seq #(.CLK_NS(CLK_NS), .GRADE_NS(GRADE_NS)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .accept    (accept),
    .capture   (capture),
    .sel_nxt   (sel_nxt),
    .cs_n      (mem_cs_n),
    .cs_hi     (mem_cs_hi),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe),
    .ack       (req_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    srbus_lane #(.W(LANE_W)) lane_i (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .en_in    (req_be[i]),
      .wdata_in (req_wdata[i*LANE_W +: LANE_W]),
      .sel_nxt  (sel_nxt),
      .capture  (capture),
      .dq_in    (mem_dq_in[i*LANE_W +: LANE_W]),
      .strobe_n (mem_lane_n[i]),
      .dq_out   (mem_dq_out[i*LANE_W +: LANE_W]),
      .rdata    (rsp_rdata[i*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/srbus_ctrl_chk.sv
module srbus_ctrl_chk
  import srbus_pkg::*;
#(
  parameter int CLK_NS   = 4,
  parameter int GRADE_NS = 55,
  parameter int LANES    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ack,
  input logic             mem_cs_n,
  input logic             mem_cs_hi,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic [LANES-1:0] mem_lane_n,
  input logic             mem_dq_oe
);

  localparam int RD_MIN    = rd_cycles(GRADE_NS, CLK_NS);
  localparam int PULSE_MIN = pulse_min(GRADE_NS, CLK_NS);

  int unsigned we_lo;
  int unsigned oe_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo <= 0;
      oe_lo <= 0;
    end else begin
      we_lo <= mem_we_n ? 0 : we_lo + 1;
      oe_lo <= mem_oe_n ? 0 : oe_lo + 1;
    end
  end

  AST_ACK_STANDBY: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (mem_cs_n && !mem_cs_hi && (&mem_lane_n) && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1
  AST_READ_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (mem_oe_n && oe_lo != 0) |-> (oe_lo >= RD_MIN)); // R9
  AST_READ_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_cs_n && mem_cs_hi && mem_we_n)); // R2
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (mem_we_n && we_lo != 0) |-> (we_lo >= PULSE_MIN)); // R4
  AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n)); // R4
  AST_WE_PREDRIVE: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_dq_oe)); // R4
  AST_WE_POSTDRIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe); // R4
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !(&mem_lane_n) |-> (!mem_cs_n && mem_cs_hi)); // R5
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack); // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R7
  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R8

endmodule

bind srbus_ctrl srbus_ctrl_chk #(
  .CLK_NS   (CLK_NS),
  .GRADE_NS (GRADE_NS),
  .LANES    (LANES)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_ack    (req_ack),
  .mem_cs_n   (mem_cs_n),
  .mem_cs_hi  (mem_cs_hi),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_lane_n (mem_lane_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/srbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module srbus_ctrl_tb_top;

  localparam int CLK_NS  = 4;
  localparam int AW      = 18;
  localparam int RD_MIN  = (55 + CLK_NS - 1) / CLK_NS;
  localparam int PWE_MIN = (40 + CLK_NS - 1) / CLK_NS;
  localparam int SD_MIN  = (25 + CLK_NS - 1) / CLK_NS;
  localparam int HZ_MIN  = (20 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be    = '0;
  logic          req_ack;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_cs_hi, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]    mem_lane_n;
  logic [15:0]   mem_dq_out;
  logic [15:0]   mem_dq_in = 16'hEEEE;

  srbus_ctrl #(.CLK_NS(CLK_NS), .GRADE_NS(55), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs_hi(mem_cs_hi), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_issued = 0;
  int n_acks = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic        rd;
    logic [15:0] d;
  } exp_t;
  exp_t sb_q[$];
  logic [15:0] shadow[int];

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] be, input bit keep);
    exp_t e;
    logic [15:0] cur;
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    if (wr) begin
      if (be[0]) cur[7:0] = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      shadow[int'(a)] = cur;
      e.rd = 1'b0;
      e.d  = 16'h0;
    end else begin
      e.rd = 1'b1;
      e.d  = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
    end
    sb_q.push_back(e);
    n_issued++;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    do @(negedge clk); while (!req_ack);
    if (!keep) req_valid = 1'b0;
  endtask

  logic prev_ack = 1'b0;
  always @(negedge clk) begin
    if (!rst && req_ack) begin
      exp_t e;
      n_acks++;
      check(!prev_ack, "R6 acknowledge longer than one cycle", 32'(prev_ack), 0);
      if (sb_q.size() == 0) begin
        check(1'b0, "R6 acknowledge without request", 1, 0);
      end else begin
        e = sb_q.pop_front();
        if (e.rd) check(rsp_rdata == e.d, "R2/R3 read data", 32'(rsp_rdata), 32'(e.d));
      end
    end
    prev_ack = req_ack;
  end

  // ---------------- memory model ----------------
  logic [15:0] mem_m[int];
  int rd_age = 0, rd_adr = 0;
  int wlo = 0, wstab = 0, stab = 0, wadr = 0;
  logic [15:0] wdat = '0;
  logic [1:0]  wln = 2'b11;
  bit wdrv = 1'b1;
  int oe_hi = 0, olo = 0, rel = 0;
  logic [15:0] pdq = '0;
  bit pdq_v = 1'b0;
  bit poe_n = 1'b1;

  always @(negedge clk) begin
    bit sel;
    int a;
    logic [15:0] cur;
    sel = !mem_cs_n && mem_cs_hi && (mem_lane_n != 2'b11);
    a = int'(mem_addr);
    if (!rst) begin
      oe_hi = mem_oe_n ? oe_hi + 1 : 0;
      if (mem_dq_oe && !pdq_v)
        check(oe_hi > HZ_MIN, "R8 bus driven too soon after output enable", oe_hi, HZ_MIN + 1);
      if (!mem_oe_n && poe_n)
        check(rel >= 1, "R7 no released cycle before read", rel, 1);
      rel = mem_dq_oe ? 0 : rel + 1;
      if (mem_oe_n && !poe_n)
        check(olo >= RD_MIN, "R9 read strobe length", olo, RD_MIN);
      olo = mem_oe_n ? 0 : olo + 1;
      if (mem_dq_oe) stab = (pdq_v && mem_dq_out == pdq) ? stab + 1 : 1;
      else stab = 0;
      if (sel && !mem_we_n) begin
        if (wlo == 0) wdrv = 1'b1;
        wlo++;
        wdat  = mem_dq_out;
        wln   = mem_lane_n;
        wadr  = a;
        wstab = stab;
        wdrv  = wdrv && mem_dq_oe;
      end else if (wlo > 0) begin
        check(wlo >= PWE_MIN, "R4 write pulse width", wlo, PWE_MIN);
        check(wstab >= SD_MIN, "R4 data setup", wstab, SD_MIN);
        check(mem_dq_oe, "R4 data hold after write", 32'(mem_dq_oe), 1);
        check(wdrv, "R4 bus driven during pulse", 32'(wdrv), 1);
        cur = mem_m.exists(wadr) ? mem_m[wadr] : 16'h0;
        if (!wln[0]) cur[7:0] = wdat[7:0];
        if (!wln[1]) cur[15:8] = wdat[15:8];
        mem_m[wadr] = cur;
        wlo = 0;
      end
      if (sel && !mem_oe_n && mem_we_n)
        rd_age = (rd_age > 0 && a == rd_adr) ? rd_age + 1 : 1;
      else
        rd_age = 0;
      rd_adr = a;
    end
    cur = mem_m.exists(rd_adr) ? mem_m[rd_adr] : 16'h0;
    for (int i = 0; i < 2; i++) begin
      if (rd_age > 0 && !mem_lane_n[i])
        mem_dq_in[i*8 +: 8] = (rd_age >= RD_MIN) ? cur[i*8 +: 8] : 8'h5A;
      else
        mem_dq_in[i*8 +: 8] = 8'hEE;
    end
    pdq   = mem_dq_out;
    pdq_v = mem_dq_oe;
    poe_n = mem_oe_n;
  end

  task automatic check_standby(input string tag);
    check(mem_cs_n && !mem_cs_hi && mem_lane_n == 2'b11 && mem_oe_n && mem_we_n && !mem_dq_oe,
          tag, {26'h0, mem_cs_n, mem_cs_hi, mem_lane_n, mem_oe_n, mem_dq_oe}, 32'h2E);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(negedge clk);
    check_standby("R1 standby during reset");
    rst = 1'b0;
    @(negedge clk);
    check_standby("R1 standby after reset");
    check(req_ack == 1'b0, "R6 no acknowledge after reset", 32'(req_ack), 0);

    issue(1'b1, 18'h00010, 16'h1234, 2'b11, 1'b0);   // full write
    issue(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0);   // R2 read back
    issue(1'b1, 18'h00010, 16'hAB99, 2'b10, 1'b0);   // R5 upper lane only
    issue(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0);
    issue(1'b0, 18'h00010, 16'h0000, 2'b01, 1'b0);   // R3 lower only
    issue(1'b0, 18'h00010, 16'h0000, 2'b10, 1'b0);   // R3 upper only
    issue(1'b1, 18'h00010, 16'h5555, 2'b00, 1'b0);   // R5 no lanes
    issue(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0);
    repeat (3) @(negedge clk);
    check_standby("R1 standby between accesses");

    // R7 / R6: chained requests, top address
    issue(1'b1, 18'h3FFFF, 16'hBEEF, 2'b11, 1'b1);
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b11, 1'b1);
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b11, 1'b1);
    issue(1'b1, 18'h00000, 16'hC001, 2'b01, 1'b1);
    issue(1'b1, 18'h00000, 16'h7F00, 2'b10, 1'b1);
    issue(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0);

    for (int k = 0; k < 12; k++)
      issue(1'b1, 18'(k * 4099 + 7), 16'(k * 16'h1357) ^ 16'hC3A5, 2'(k % 3 + 1), k[0]);
    for (int k = 0; k < 12; k++)
      issue(1'b0, 18'(k * 4099 + 7), 16'h0000, 2'b11, (k % 4) != 3);
    req_valid = 1'b0;

    repeat (4) @(negedge clk);
    check_standby("R1 standby at end");
    check(sb_q.size() == 0, "R6 outstanding expectations", sb_q.size(), 0);
    check(n_acks == n_issued, "R6 acknowledge count", n_acks, n_issued);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

endmodule